// File: doc/BRIEF.md
# SD Data Timeout Counter

This block watches an SD data transfer for lack of progress. While a transfer is active and the card clock is enabled, it counts card clock ticks. The count restarts whenever the data path reports activity: the start of a transfer, a block boundary, or a received start bit. If the count reaches the programmed window before any such event, the block raises a sticky data-timeout flag and ends the transfer. No completion flag is raised for a transfer that ends this way.

The window comes from a 4-bit exponent code `n` held in bits 19:16 of a control word. The window is 2^(n+BASE_EXP) card clock ticks, and BASE_EXP is 13 by default. Code 14 is the largest valid code, and code 15 acts as 14.

Bit 24 of the same control word requests a data-path reset. That bit clears itself after one cycle. The status word holds the timeout flag and the transfer-complete flag, and both are cleared by writing ones.

Top module: `sd_data_timeout`

## Requirements
- R1: After rst_ni is released, busy_o is 0, sts_o is 0 and ctl_rdata_o is 0.
- R2: A control write stores ctl_wdata_i[19:16] as the timeout code, which reads back at ctl_rdata_o[19:16] from the next cycle. With code n, the timeout flag sets on the 2^(n+BASE_EXP)-th counted tick after the last restart.
- R3: Code 15 reads back as 15 but gives the same window as code 14.
- R4: A tick counts only on a host clock edge where busy_o, card_clk_en_i and card_tick_i are all 1. No timeout can rise while busy_o is 0.
- R5: xfer_start_i, blk_evt_i or start_bit_i clears the tick count on that edge, and that edge's tick is not counted.
- R6: A timeout sets sts_o[20] on the edge of the final counted tick and clears busy_o on that same edge.
- R7: xfer_done_i while busy_o is 1 clears busy_o and sets sts_o[1] on the next edge. xfer_start_i while idle sets busy_o.
- R8: A status write clears each flag whose sts_wdata_i bit is 1 and leaves the other flags unchanged. A flag being set on the same edge wins over its clear.
- R9: A control write with ctl_wdata_i[24]=1 makes ctl_rdata_o[24] read 1 for one cycle and 0 on the next. On that following edge busy_o clears and the count clears, while sts_o keeps its value.
- R10: If a timeout and xfer_done_i fall on the same edge, only sts_o[20] sets and sts_o[1] stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control write data (19:16 code, 24 data reset) |
| ctl_rdata_o | output | 32 | Control word readback |
| sts_wr_i | input | 32 | Status write strobe (write-one-to-clear) |
| sts_wdata_i | input | 32 | Status clear mask |
| sts_o | output | 32 | Status word (20 timeout, 1 complete) |
| xfer_start_i | input | 1 | Data transfer begins |
| xfer_done_i | input | 1 | Data transfer finished normally |
| card_clk_en_i | input | 1 | Card clock enable |
| card_tick_i | input | 1 | One pulse per card clock cycle |
| blk_evt_i | input | 1 | Block boundary seen |
| start_bit_i | input | 1 | Start bit received on the data lines |
| busy_o | output | 1 | Transfer active |

Correction to the table above: sts_wr_i is 1 bit wide.

## Verification
The assertions check several properties on every cycle:
- the code readback and the one-cycle life of the reset bit;
- the end of the transfer on a data reset;
- the fact that a timeout never rises while idle and always coincides with busy_o dropping;
- the stickiness of the timeout flag;
- the exclusion of a completion flag on a timeout edge.

The exact window length, the effect of restarts and clock gaps, and the cap of code 15 at 14 can only be shown by the bench's scenarios. Those scenarios count the ticks to a timeout. The behavioural model compares the three outputs on every clock.

// File: rtl/sdto_pkg.sv
package sdto_pkg;
  localparam int WORD_W   = 32;
  localparam int CODE_W   = 4;
  localparam int CODE_LSB = 16;
  localparam int DRST_BIT = 24;
  localparam int DTO_BIT  = 20;
  localparam int CMP_BIT  = 1;
  localparam int NFLAG    = 2;
  typedef enum int {FL_DTO = 0, FL_CMP = 1} flag_e;
endpackage

// File: rtl/sdto_ctl.sv
module sdto_ctl
  import sdto_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_wr_i,
  input  logic              drst_wr_i,
  output logic [CODE_W-1:0] code_o,
  output logic              drst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      drst_o <= 1'b0;
    end else if (wr_i) begin
      code_o <= code_wr_i;
      drst_o <= drst_wr_i;
    end else begin
      drst_o <= 1'b0; // self-clearing
    end
  end
endmodule

// File: rtl/sdto_window.sv
module sdto_window
  import sdto_pkg::*;
#(
  parameter int BASE_EXP = 13,
  parameter int MAX_CODE = 14,
  localparam int CW = MAX_CODE + BASE_EXP
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CW-1:0]     term_o
);
  logic [CODE_W-1:0] eff_code;
  int unsigned       sh;

  always_comb begin
    eff_code = (int'(code_i) > MAX_CODE) ? CODE_W'(MAX_CODE) : code_i;
    sh       = int'(eff_code) + BASE_EXP;
    term_o   = ~({CW{1'b1}} << sh); // 2^sh - 1
  end
endmodule

// File: rtl/sdto_counter.sv
module sdto_counter #(
  parameter int CW = 27
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          restart_i,
  input  logic          adv_i,
  input  logic [CW-1:0] term_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  assign hit_o = adv_i && !restart_i && (cnt_q == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i || restart_i || hit_o) cnt_q <= '0;
    else if (adv_i)                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdto_w1c.sv
module sdto_w1c #(
  parameter int NF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] q_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1; // set wins
      else if (clr_i[g]) q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/sd_data_timeout.sv
module sd_data_timeout
  import sdto_pkg::*;
#(
  parameter int BASE_EXP = 13,
  parameter int MAX_CODE = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [WORD_W-1:0] ctl_wdata_i,
  output logic [WORD_W-1:0] ctl_rdata_o,
  input  logic              sts_wr_i,
  input  logic [WORD_W-1:0] sts_wdata_i,
  output logic [WORD_W-1:0] sts_o,
  input  logic              xfer_start_i,
  input  logic              xfer_done_i,
  input  logic              card_clk_en_i,
  input  logic              card_tick_i,
  input  logic              blk_evt_i,
  input  logic              start_bit_i,
  output logic              busy_o
);
  localparam int CW = MAX_CODE + BASE_EXP;

  logic [CODE_W-1:0] code;
  logic              drst;
  logic [CW-1:0]     term;
  logic              restart, adv, hit;
  logic              active_q;
  logic [NFLAG-1:0]  flag_set, flag_clr, flags;
  logic              unused_bits;

  assign unused_bits = ^{ctl_wdata_i[WORD_W-1:DRST_BIT+1],
                         ctl_wdata_i[DRST_BIT-1:CODE_LSB+CODE_W],
                         ctl_wdata_i[CODE_LSB-1:0],
                         sts_wdata_i[WORD_W-1:DTO_BIT+1],
                         sts_wdata_i[DTO_BIT-1:CMP_BIT+1],
                         sts_wdata_i[0]};

  sdto_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctl_wr_i),
    .code_wr_i (ctl_wdata_i[CODE_LSB +: CODE_W]),
    .drst_wr_i (ctl_wdata_i[DRST_BIT]),
    .code_o    (code),
    .drst_o    (drst)
  );

  sdto_window #(.BASE_EXP(BASE_EXP), .MAX_CODE(MAX_CODE)) u_win (
    .code_i (code),
    .term_o (term)
  );

  assign restart = xfer_start_i || blk_evt_i || start_bit_i;
  assign adv     = active_q && card_clk_en_i && card_tick_i;

  sdto_counter #(.CW(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (drst),
    .restart_i (restart),
    .adv_i     (adv),
    .term_i    (term),
    .hit_o     (hit)
  );

  // priority: data reset > timeout > done > start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       active_q <= 1'b0;
    else if (drst || hit)              active_q <= 1'b0;
    else if (active_q && xfer_done_i)  active_q <= 1'b0;
    else if (xfer_start_i)             active_q <= 1'b1;
  end

  always_comb begin
    flag_set         = '0;
    flag_set[FL_DTO] = hit && !drst;
    flag_set[FL_CMP] = active_q && xfer_done_i && !hit && !drst;
    flag_clr         = '0;
    flag_clr[FL_DTO] = sts_wr_i && sts_wdata_i[DTO_BIT];
    flag_clr[FL_CMP] = sts_wr_i && sts_wdata_i[CMP_BIT];
  end

  sdto_w1c #(.NF(NFLAG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .q_o    (flags)
  );

  always_comb begin
    sts_o                         = '0;
    sts_o[DTO_BIT]                = flags[FL_DTO];
    sts_o[CMP_BIT]                = flags[FL_CMP];
    ctl_rdata_o                   = '0;
    ctl_rdata_o[CODE_LSB +: CODE_W] = code;
    ctl_rdata_o[DRST_BIT]         = drst;
  end

  assign busy_o = active_q;
endmodule

// File: rtl/sdto_chk.sv
module sdto_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctl_wr_i,
  input logic [3:0] code_wr_i,
  input logic       drst_wr_i,
  input logic [3:0] code_rd_i,
  input logic       drst_rd_i,
  input logic       sts_wr_i,
  input logic       dto_clr_i,
  input logic       dto_i,
  input logic       cmp_i,
  input logic       xfer_done_i,
  input logic       busy_i
);
  AST_CODE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i |=> code_rd_i == $past(code_wr_i)); // R2
  AST_DRST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drst_rd_i && !(ctl_wr_i && drst_wr_i)) |=> !drst_rd_i); // R9
  AST_DRST_ENDS_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drst_rd_i |=> !busy_i); // R9
  AST_DTO_ENDS_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dto_i) |-> !busy_i); // R6
  AST_NO_IDLE_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !$rose(dto_i)); // R4
  AST_NO_CMP_ON_DTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dto_i) |-> !$rose(cmp_i)); // R10
  AST_DTO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dto_i && !(sts_wr_i && dto_clr_i)) |=> dto_i); // R8
  AST_DONE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && xfer_done_i && !drst_rd_i) |=> (cmp_i || dto_i) && !busy_i); // R7
endmodule

bind sd_data_timeout sdto_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_wr_i    (ctl_wr_i),
  .code_wr_i   (ctl_wdata_i[19:16]),
  .drst_wr_i   (ctl_wdata_i[24]),
  .code_rd_i   (ctl_rdata_o[19:16]),
  .drst_rd_i   (ctl_rdata_o[24]),
  .sts_wr_i    (sts_wr_i),
  .dto_clr_i   (sts_wdata_i[20]),
  .dto_i       (sts_o[20]),
  .cmp_i       (sts_o[1]),
  .xfer_done_i (xfer_done_i),
  .busy_i      (busy_o)
);

// File: tb/sd_data_timeout_test.sv
`timescale 1ns/1ps
module sd_data_timeout_test;
  localparam int BE = 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctl_wr = 0, sts_wr = 0;
  logic [31:0] ctl_wdata = '0, sts_wdata = '0;
  logic        start = 0, done = 0, en = 0, tick = 0, blk = 0, sb = 0;
  logic [31:0] ctl_rdata, sts;
  logic        busy;
  int          nvec = 0, nerr = 0;

  always #2.5 clk = ~clk;

  sd_data_timeout #(.BASE_EXP(BE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .ctl_rdata_o(ctl_rdata), .sts_wr_i(sts_wr), .sts_wdata_i(sts_wdata), .sts_o(sts),
    .xfer_start_i(start), .xfer_done_i(done), .card_clk_en_i(en), .card_tick_i(tick),
    .blk_evt_i(blk), .start_bit_i(sb), .busy_o(busy));

  task automatic chk(input string tag, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int     m_code;
  bit     m_rst, m_busy, m_dto, m_cmp;
  longint m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_rst = 0; m_busy = 0; m_dto = 0; m_cmp = 0; m_cnt = 0;
    end else begin
      longint lim;
      bit adv, rs, hit, cset, nbusy;
      lim   = longint'(1) << ((m_code > 14 ? 14 : m_code) + BE);
      adv   = m_busy && en && tick;
      rs    = start || blk || sb;
      hit   = !m_rst && adv && !rs && (m_cnt == lim - 1);
      cset  = !m_rst && !hit && m_busy && done;
      nbusy = m_rst ? 0 : hit ? 0 : (m_busy && done) ? 0 : start ? 1 : m_busy;
      if (m_rst || rs || hit) m_cnt = 0;
      else if (adv)           m_cnt = m_cnt + 1;
      m_dto = hit  || (m_dto && !(sts_wr && sts_wdata[20]));
      m_cmp = cset || (m_cmp && !(sts_wr && sts_wdata[1]));
      m_busy = nbusy;
      if (ctl_wr) begin m_code = int'(ctl_wdata[19:16]); m_rst = ctl_wdata[24]; end
      else m_rst = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R7 busy_o vs model", busy, m_busy);
    chk("R8 sts_o vs model", sts, (longint'(m_dto) << 20) | (longint'(m_cmp) << 1));
    chk("R2 ctl_rdata_o vs model", ctl_rdata, (longint'(m_code) << 16) | (longint'(m_rst) << 24));
  end

  task automatic wr_ctl(input int code, input bit drst);
    ctl_wr = 1; ctl_wdata = (32'(drst) << 24) | (32'(code) << 16);
    @(negedge clk); ctl_wr = 0; ctl_wdata = '0;
  endtask
  task automatic wr_sts(input logic [31:0] v);
    sts_wr = 1; sts_wdata = v; @(negedge clk); sts_wr = 0; sts_wdata = '0;
  endtask
  task automatic start_x();
    start = 1; @(negedge clk); start = 0;
  endtask
  task automatic ticks_to_dto(input bit gaps, output int n);
    n = 0;
    for (int i = 0; i < 40000; i++) begin
      en   = gaps ? (i % 3 != 1) : 1'b1;
      tick = gaps ? (i % 4 != 3) : 1'b1;
      @(negedge clk);
      if (en && tick) n++;
      if (sts[20]) break;
    end
    en = 0; tick = 0;
  endtask

  initial begin
    #(100000 * 5);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset sts", sts, 0);
    chk("R1 reset ctl", ctl_rdata, 0);

    // R2: window length per code, readback
    wr_ctl(0, 0);
    start_x();
    ticks_to_dto(0, n);
    chk("R2 code0 ticks", n, 2);
    chk("R6 busy cleared on timeout", busy, 0);
    chk("R6 dto flag only", sts, 32'h0010_0000);
    wr_sts('1);
    wr_ctl(2, 0);
    chk("R2 code readback", ctl_rdata, 32'h0002_0000);
    start_x();
    ticks_to_dto(0, n);
    chk("R2 code2 ticks", n, 8);

    // R4: gapped ticks
    wr_sts('1);
    wr_ctl(3, 0);
    start_x();
    ticks_to_dto(1, n);
    chk("R4 gapped ticks", n, 16);

    // R5: block boundary and start bit restart
    wr_sts('1);
    start_x();
    en = 1; tick = 1;
    repeat (10) @(negedge clk);
    blk = 1; @(negedge clk); blk = 0;
    chk("R5 busy after blk restart", busy, 1);
    ticks_to_dto(0, n);
    chk("R5 ticks after blk restart", n, 16);
    wr_sts('1);
    start_x();
    en = 1; tick = 1;
    repeat (15) @(negedge clk);
    sb = 1; @(negedge clk); sb = 0;
    chk("R5 no timeout after start bit", sts, 0);
    ticks_to_dto(0, n);
    chk("R5 ticks after start bit", n, 16);

    // R7: normal completion
    wr_sts('1);
    start_x();
    chk("R7 busy set by start", busy, 1);
    en = 1; tick = 1;
    repeat (5) @(negedge clk);
    done = 1; @(negedge clk); done = 0; en = 0; tick = 0;
    chk("R7 busy cleared by done", busy, 0);
    chk("R7 complete flag", sts, 32'h2);

    // R10: timeout and done on same edge
    wr_sts('1);
    wr_ctl(0, 0);
    start_x();
    en = 1; tick = 1;
    @(negedge clk);
    done = 1; @(negedge clk); done = 0; en = 0; tick = 0;
    chk("R10 only dto flag", sts, 32'h0010_0000);
    chk("R10 busy cleared", busy, 0);

    // R8: write-one-to-clear
    start_x();
    done = 1; @(negedge clk); done = 0;
    chk("R8 both flags", sts, 32'h0010_0002);
    wr_sts(32'h0);
    chk("R8 zero write keeps flags", sts, 32'h0010_0002);
    wr_sts(32'h0010_0000);
    chk("R8 selective clear", sts, 32'h2);
    wr_sts('1);
    start_x();
    done = 1; sts_wr = 1; sts_wdata = '1;
    @(negedge clk); done = 0; sts_wr = 0; sts_wdata = '0;
    chk("R8 set wins over clear", sts, 32'h2);

    // R9: self-clearing data reset mid-transfer
    wr_ctl(3, 0);
    start_x();
    en = 1; tick = 1;
    repeat (4) @(negedge clk);
    wr_ctl(3, 1);
    chk("R9 reset bit reads one", ctl_rdata, 32'h0103_0000);
    chk("R9 busy before reset edge", busy, 1);
    @(negedge clk);
    chk("R9 reset bit self-clears", ctl_rdata, 32'h0003_0000);
    chk("R9 busy cleared", busy, 0);
    chk("R9 flags kept", sts, 32'h2);
    repeat (40) @(negedge clk);
    chk("R4 no timeout while idle", sts, 32'h2);
    en = 0; tick = 0;

    // R3: code 15 acts as 14
    wr_sts('1);
    wr_ctl(15, 0);
    chk("R3 code15 readback", ctl_rdata, 32'h000f_0000);
    start_x();
    ticks_to_dto(0, n);
    chk("R3 code15 ticks", n, 32768);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule